// File: doc/BRIEF.md
# Sync-Driven Field Parity Detector

This block decides, for each vertical sync pulse that arrives from outside, whether the field it starts is odd or even. It is used in a video encoder that follows external timing. The horizontal and vertical sync inputs are both active low. They are sampled only on cycles where the pixel clock enable is high. These enabled cycles are called ticks below.

For each pulse, the block counts how many ticks vertical sync stays low. It also checks where the vertical falling edge sits against the nearby horizontal sync pulse. A field is odd only if it passes both tests; every other field is even. Each decision comes out as a one-cycle strobe that carries the odd/even flag. The block also reports the low width of the most recent completed pulse.

Top module: `field_parity_detect`

## Requirements
- R1: Inputs are sampled only on ticks (cycles with `ce` high). A cycle with `ce` low never raises `field_valid`, and it does not move the timing of a decision.
- R2: Each vertical low pulse whose falling edge is seen after reset produces exactly one `field_valid` strobe.
- R3: A field is reported odd only if vertical sync is sampled low on at least MIN_LOW consecutive ticks (default 128). A shorter pulse is reported even.
- R4: Let tv be the tick of the first low vertical sample, thf the tick of the first low horizontal sample of the same horizontal pulse, and thr the tick of its first high sample afterwards. The window test passes when thf-1 <= tv <= thr-2. Equivalently, horizontal sync is sampled low on tick tv+1.
- R5: A field that fails the width test or the window test is reported as even (`field_odd` = 0).
- R6: `field_valid` is high for exactly one clock, in the cycle after a deciding tick. The deciding tick is the later of two ticks: the tick with the MIN_LOW-th low sample, and the tick that completes the window test. The window test completes at the horizontal rising tick on a pass, or at tv+1 on a fail. If vertical sync returns high before both have happened, the deciding tick is the rising tick and the result is even.
- R7: `low_width` takes the number of low ticks of a pulse at the tick where vertical sync is sampled high again. The count saturates at 2^CNT_W-1 (65535 by default).
- R8: Reset is synchronous and active high, and clears `field_odd`, `field_valid` and `low_width` to 0. `field_odd` changes only together with a strobe, and it holds its value between strobes.
- R9: A vertical low pulse already in progress when reset is released produces no strobe and leaves `low_width` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Pixel clock enable; one tick per high cycle |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 = last decided field odd, 0 = even |
| field_valid | output | 1 | One-cycle decision strobe |
| low_width | output | CNT_W | Low ticks of the last completed vertical pulse |

## Verification
The bench goes after both edges of the window, one tick inside and one tick outside each. Getting the early limit wrong would turn the horizontal-falls-one-tick-later case even. Getting the late limit wrong would accept a horizontal pulse that rises one tick after vertical falls.

Pulse widths of 127 and 128 ticks test the width threshold. A design with an off-by-one count would misjudge one of them, or would raise its strobe a tick early or late. Further cases cover:
- a horizontal rise after tick 127, where the strobe must wait for it;
- a horizontal pulse that outlasts the vertical one, which must give an even result at the rising tick;
- gapped enables, where an ungated path would shift the decision tick;
- a 70000-tick pulse, where a counter that wraps would report a small width;
- reset in the middle of a pulse, where a design that does not ignore it would emit a spurious even strobe.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  // Progress of the edge-window test for the current vertical pulse
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_PROBE = 2'd1,
    W_ARMED = 2'd2,
    W_DONE  = 2'd3
  } win_state_t;
endpackage

// File: rtl/fpd_edge_sampler.sv
module fpd_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic hsync_n,
  input  logic vsync_n,
  output logic vs_fall,
  output logic vs_rise,
  output logic vs_low,
  output logic hs_low,
  output logic hs_rise
);
  logic vs_q, hs_q;

  // vs_q resets low so a pulse already running at reset shows no falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b0;
      hs_q <= 1'b1;
    end else if (ce) begin
      vs_q <= vsync_n;
      hs_q <= hsync_n;
    end
  end

  always_comb begin
    vs_fall = ce & vs_q & ~vsync_n;
    vs_rise = ce & ~vs_q & vsync_n;
    vs_low  = ce & ~vsync_n;
    hs_low  = ~hsync_n;
    hs_rise = ce & ~hs_q & hsync_n;
  end
endmodule

// File: rtl/fpd_width_counter.sv
module fpd_width_counter #(
  parameter int CNT_W   = 16,
  parameter int MIN_LOW = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vs_fall,
  input  logic             vs_rise,
  input  logic             vs_low,
  output logic             reach_now,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] low_width
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_M1  = CNT_W'(MIN_LOW - 1);
  localparam bit               FIRST_OK = (MIN_LOW <= 1);

  logic in_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pulse  <= 1'b0;
      run_cnt   <= '0;
      low_width <= '0;
    end else if (vs_fall) begin
      in_pulse <= 1'b1;
      run_cnt  <= CNT_W'(1);
    end else if (vs_low && in_pulse) begin
      if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end else if (vs_rise && in_pulse) begin
      in_pulse  <= 1'b0;
      low_width <= run_cnt;
    end
  end

  // True on every low tick whose count, this tick included, is at least MIN_LOW
  always_comb begin
    if (vs_fall) reach_now = FIRST_OK;
    else         reach_now = vs_low & in_pulse & (run_cnt >= MIN_M1);
  end

  // R7: the count holds at its ceiling instead of wrapping
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (vs_low && !vs_fall && in_pulse && run_cnt == CNT_MAX) |=> (run_cnt == CNT_MAX));
endmodule

// File: rtl/fpd_window_check.sv
module fpd_window_check
  import fpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic vs_fall,
  input  logic hs_low,
  input  logic hs_rise,
  output logic done_now,
  output logic ok_now
);
  win_state_t wst;
  logic ok_q, pass_now, fail_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst  <= W_IDLE;
      ok_q <= 1'b0;
    end else if (vs_fall) begin
      wst  <= W_PROBE;
      ok_q <= 1'b0;
    end else begin
      case (wst)
        W_PROBE: if (tick) wst <= hs_low ? W_ARMED : W_DONE;
        W_ARMED: if (hs_rise) begin
          wst  <= W_DONE;
          ok_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Horizontal sync must be low on the tick after the vertical fall;
  // the test completes when that horizontal pulse ends
  always_comb begin
    pass_now = (wst == W_ARMED) & hs_rise & ~vs_fall;
    fail_now = (wst == W_PROBE) & tick & ~hs_low & ~vs_fall;
    done_now = (wst == W_DONE) | pass_now | fail_now;
    ok_now   = ok_q | pass_now;
  end

  // R4: a pass is only recorded once the window test has completed
  assert_pass_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (wst == W_DONE));
endmodule

// File: rtl/field_parity_detect.sv
module field_parity_detect #(
  parameter int CNT_W   = 16,
  parameter int MIN_LOW = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             hsync_n,
  input  logic             vsync_n,
  output logic             field_odd,
  output logic             field_valid,
  output logic [CNT_W-1:0] low_width
);
  localparam logic [CNT_W-1:0] MIN_CMP = CNT_W'(MIN_LOW);

  logic vs_fall, vs_rise, vs_low, hs_low, hs_rise;
  logic reach_now, done_now, ok_now;
  logic [CNT_W-1:0] run_cnt;
  logic decided, fire_low, fire_rise;

  fpd_edge_sampler u_edge (
    .clk(clk), .rst(rst), .ce(ce), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .vs_fall(vs_fall), .vs_rise(vs_rise), .vs_low(vs_low),
    .hs_low(hs_low), .hs_rise(hs_rise)
  );

  fpd_width_counter #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) u_width (
    .clk(clk), .rst(rst), .vs_fall(vs_fall), .vs_rise(vs_rise), .vs_low(vs_low),
    .reach_now(reach_now), .run_cnt(run_cnt), .low_width(low_width)
  );

  fpd_window_check u_win (
    .clk(clk), .rst(rst), .tick(ce), .vs_fall(vs_fall),
    .hs_low(hs_low), .hs_rise(hs_rise),
    .done_now(done_now), .ok_now(ok_now)
  );

  // Decide on the later of width reached and window complete; if vertical
  // sync ends first, decide even at its rising tick
  always_comb begin
    fire_low  = vs_low & ~decided & reach_now & done_now;
    fire_rise = vs_rise & ~decided;
  end

  // decided resets high: no decision owed until a fresh falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      decided     <= 1'b1;
      field_odd   <= 1'b0;
      field_valid <= 1'b0;
    end else begin
      field_valid <= 1'b0;
      if (vs_fall) begin
        decided <= 1'b0;
      end else if (fire_low) begin
        decided     <= 1'b1;
        field_valid <= 1'b1;
        field_odd   <= ok_now;
      end else if (fire_rise) begin
        decided     <= 1'b1;
        field_valid <= 1'b1;
        field_odd   <= 1'b0;
      end
    end
  end

  // R6: the strobe lasts one clock
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    field_valid |=> !field_valid);

  // R3: an odd result implies the low run reached the minimum width
  assert_odd_needs_width_R3: assert property (@(posedge clk) disable iff (rst)
    (field_valid && field_odd) |-> (run_cnt >= MIN_CMP));

  // R8: the flag only moves together with a strobe
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> field_valid);

  // R1: no strobe follows a cycle without an enable
  assert_idle_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(ce) |-> !field_valid);
endmodule

// File: tb/tb_field_parity_detect.sv
module tb_field_parity_detect;
  logic clk = 1'b0;
  logic rst, ce, hsync_n, vsync_n;
  logic field_odd, field_valid;
  logic [15:0] low_width;
  int n_checks = 0;
  int n_err = 0;
  int stray = 0;
  bit gap = 0;

  field_parity_detect dut (
    .clk(clk), .rst(rst), .ce(ce), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .field_odd(field_odd), .field_valid(field_valid), .low_width(low_width)
  );

  always #10 clk = ~clk;

  // Vectors: horizontal fall tick, horizontal low length, vertical low length
  // (all relative to the vertical fall at tick 0), expected odd, decision tick
  localparam int NV = 12;
  localparam int V_HF   [NV] = '{0, 1, 2, -5, -5, 0, 0, 0, 0, 0, -1, 1};
  localparam int V_HL   [NV] = '{10, 10, 10, 7, 6, 10, 10, 200, 400, 5, 3, 1};
  localparam int V_VL   [NV] = '{200, 200, 200, 200, 200, 128, 127, 300, 300, 20, 150, 200};
  localparam int V_ODD  [NV] = '{1, 1, 0, 1, 0, 1, 0, 1, 0, 0, 1, 1};
  localparam int V_FIRE [NV] = '{127, 127, 127, 127, 127, 127, 127, 200, 300, 20, 127, 127};

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic h, input logic v);
    if (gap) begin
      @(negedge clk);
      ce = 1'b0;
      @(posedge clk);
      #2;
      if (field_valid) stray++;
    end
    @(negedge clk);
    hsync_n = h;
    vsync_n = v;
    ce = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic run_vec(input int hf, input int hl, input int vl, input int eo,
                         input int ef, input bit first);
    int nfire = 0;
    int fire_t = -1;
    int got_odd = -1;
    int tend = ((vl > hf + hl) ? vl : hf + hl) + 4;
    for (int t = -8; t <= tend; t++) begin
      tick(!(t >= hf && t < hf + hl), !(t >= 0 && t < vl));
      if (field_valid) begin
        nfire++;
        fire_t = t;
        got_odd = int'(field_odd);
      end
      if (first && t == 100) chk("R8 flag even before first decision", int'(field_odd), 0);
    end
    chk("R2 one strobe per pulse", nfire, 1);
    chk("R6 decision tick", fire_t, ef);
    if (eo == 1)      chk("R4 window pass gives odd", got_odd, 1);
    else if (vl < 128) chk("R3 short pulse gives even", got_odd, 0);
    else               chk("R5 failed window gives even", got_odd, 0);
    chk("R7 low width", int'(low_width), vl > 65535 ? 65535 : vl);
    chk("R8 flag holds after strobe", int'(field_odd), eo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ce = 1'b0; hsync_n = 1'b1; vsync_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R8 reset field_odd", int'(field_odd), 0);
    chk("R8 reset field_valid", int'(field_valid), 0);
    chk("R8 reset low_width", int'(low_width), 0);

    for (int i = 0; i < NV; i++)
      run_vec(V_HF[i], V_HL[i], V_VL[i], V_ODD[i], V_FIRE[i], i == 0);

    // R1: gapped enables keep tick-based timing and never strobe off-tick
    gap = 1;
    run_vec(0, 10, 200, 1, 127, 0);
    run_vec(2, 10, 200, 0, 127, 0);
    gap = 0;
    chk("R1 no strobe on idle cycles", stray, 0);

    // R7: saturation of the width count
    run_vec(0, 10, 70000, 1, 127, 0);

    // R9: reset in the middle of a vertical pulse
    begin
      int nf = 0;
      for (int t = 0; t < 50; t++) tick(1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #2;
      chk("R8 reset clears width mid-run", int'(low_width), 0);
      for (int t = 0; t < 200; t++) begin
        tick(!(t < 10), 1'b0);
        if (field_valid) nf++;
      end
      for (int t = 0; t < 10; t++) begin
        tick(1'b1, 1'b1);
        if (field_valid) nf++;
      end
      chk("R9 no strobe for pulse begun before reset", nf, 0);
      chk("R9 width untouched by partial pulse", int'(low_width), 0);
      chk("R9 flag untouched by partial pulse", int'(field_odd), 0);
    end
    run_vec(0, 5, 20, 0, 20, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule